// File: doc/BRIEF.md
# Multi-Commit Reorder Buffer

This block keeps the program order of in-flight micro-operations for a small out-of-order core. Up to three micro-operations enter in one cycle, in program order, as a group. Each one is given an entry tag. Execution units later use that tag to report completion, together with a result value and a flag that marks a mispredicted branch. The storage is a ring of 40 entries, so tags count up and wrap back to 0 after 39.

Up to three entries leave the buffer in each cycle, oldest first and strictly in order. Each entry that leaves presents its destination register and its result value. Retirement stops at the first entry that has not completed, even when younger entries have. When a retiring entry carries the mispredict flag, it is the last entry to leave in that cycle. Every younger entry is discarded and the buffer is empty on the next cycle.

Allocation is a valid/ready interface. `alloc_valid` lanes count only as a run of ones starting at lane 0. A group moves across in a cycle where `alloc_ready` is high. The source may hold or change its request while `alloc_ready` is low. Retirement is also valid/ready: a lane retires when `cmt_valid` for that lane and `cmt_ready` are both high. When `cmt_ready` is low, nothing leaves. Completion reports have no back-pressure.

Top module: `reorder_buffer`

## Requirements
- R1: Accepted micro-operations receive consecutive tags starting at the current tail, with lane 0 the oldest. The tag after 39 is 0, and `alloc_tag` shows the tag each lane would receive.
- R2: The requested count is the number of consecutive set `alloc_valid` bits starting from lane 0; lanes above the first clear bit are ignored. `alloc_ready` is low, and nothing is written, unless the free entries cover the whole count. Entries freed by retirement in the same cycle do not count as free.
- R3: A completion report for an allocated entry marks that entry done and stores its value and mispredict flag. A report whose tag is not allocated, including tags 40 to 63, changes nothing.
- R4: In each cycle, up to three of the oldest entries retire in order, each presenting its destination register and value. Lane k carries the k-th oldest entry. Retirement stops at the first entry that is not done.
- R5: While `cmt_ready` is low, no lane reports `cmt_valid`.
- R6: When a retiring entry has its mispredict flag set, `flush` is high in that cycle and no younger lane retires. On the next cycle the buffer is empty, and the next tag is the branch tag plus one, modulo 40.
- R7: In a cycle with `flush` high, `alloc_ready` is low and any allocation request is ignored.
- R8: After reset the buffer is empty: `alloc_ready` is high, the lane 0 tag is 0, and no lane retires.
- R9: The buffer holds 40 entries. When it is full, even a one-lane request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 3 | Allocation request per lane; the run of ones from lane 0 counts |
| alloc_dst | input | 15 | Destination register per lane, 5 bits each, lane 0 in the low bits |
| alloc_ready | output | 1 | The requested group is accepted this cycle |
| alloc_tag | output | 18 | Tag per lane, 6 bits each, lane 0 in the low bits |
| cpl_valid | input | 2 | Completion report per port |
| cpl_tag | input | 12 | Tag per completion port, 6 bits each |
| cpl_value | input | 64 | Result value per completion port, 32 bits each |
| cpl_mispred | input | 2 | Mispredicted-branch flag per completion port |
| cmt_ready | input | 1 | Consumer accepts retirement this cycle |
| cmt_valid | output | 3 | Lane k retires the k-th oldest entry |
| cmt_dst | output | 15 | Destination register per retiring lane |
| cmt_value | output | 96 | Result value per retiring lane |
| flush | output | 1 | A mispredicted entry retires this cycle; younger entries are dropped |

## Verification
`alloc_ready`, `alloc_tag`, `cmt_valid`, the retired register and value, and `flush` all depend, through combinational logic only, on registered state and on the inputs of the same cycle. The bench therefore compares them in the cycle the stimulus is applied. A completion report can make an entry retire no earlier than the next cycle. A flush empties the buffer and moves the next tag on the following cycle. The bench drives inputs just after the falling edge, samples 1 ns later, and compares against a queue model. The model then advances one cycle, so every result is checked in exactly the cycle it falls due.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Ring index arithmetic for a buffer whose depth need not be a power of two.
  function automatic int unsigned ring_add(int unsigned base, int unsigned step, int unsigned size);
    int unsigned s;
    s = base + step;
    return (s >= size) ? s - size : s;
  endfunction
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned TW    = 6,
  parameter int unsigned CNTW  = 6,
  parameter int unsigned NAW   = 2,
  parameter int unsigned NCW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NAW-1:0]  nacc,
  input  logic [NCW-1:0]  ncmt,
  input  logic            squash,
  input  logic [TW-1:0]   squash_tag,
  output logic [TW-1:0]   head,
  output logic [TW-1:0]   tail,
  output logic [CNTW-1:0] count
);
  import rob_pkg::*;

  logic [TW-1:0] restart;
  assign restart = TW'(ring_add(32'(squash_tag), 32'd1, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (squash) begin
      head  <= restart;
      tail  <= restart;
      count <= '0;
    end else begin
      head  <= TW'(ring_add(32'(head), 32'(ncmt), DEPTH));
      tail  <= TW'(ring_add(32'(tail), 32'(nacc), DEPTH));
      count <= count + CNTW'(nacc) - CNTW'(ncmt);
    end
  end

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (count == '0) && (head == tail));
  p_capacity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  p_ring_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    TW'(ring_add(32'(head), 32'(count), DEPTH)) == tail);
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned AW    = 3,
  parameter int unsigned CW    = 3,
  parameter int unsigned CP    = 2,
  parameter int unsigned DW    = 32,
  parameter int unsigned RW    = 5,
  parameter int unsigned TW    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          alloc_we,
  input  logic [AW-1:0][TW-1:0]  alloc_idx,
  input  logic [AW-1:0][RW-1:0]  alloc_dst,
  input  logic [CP-1:0]          cpl_valid,
  input  logic [CP-1:0][TW-1:0]  cpl_tag,
  input  logic [CP-1:0][DW-1:0]  cpl_value,
  input  logic [CP-1:0]          cpl_misp,
  input  logic [CW-1:0]          ret_we,
  input  logic                   squash,
  input  logic [CW-1:0][TW-1:0]  rd_idx,
  output logic [CW-1:0]          rd_live,
  output logic [CW-1:0]          rd_done,
  output logic [CW-1:0]          rd_misp,
  output logic [CW-1:0][RW-1:0]  rd_dst,
  output logic [CW-1:0][DW-1:0]  rd_value
);
  logic [DEPTH-1:0]  live;
  logic [DEPTH-1:0]  done;
  logic [DEPTH-1:0]  misp;
  logic [RW-1:0]     dst_q [DEPTH];
  logic [DW-1:0]     val_q [DEPTH];
  logic [CP-1:0]     cpl_hit;

  for (genvar p = 0; p < CP; p++) begin : g_hit
    assign cpl_hit[p] = cpl_valid[p] && (cpl_tag[p] < TW'(DEPTH)) && live[cpl_tag[p]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      done <= '0;
      misp <= '0;
    end else if (squash) begin
      live <= '0;
    end else begin
      for (int k = 0; k < CW; k++)
        if (ret_we[k]) live[rd_idx[k]] <= 1'b0;
      for (int k = 0; k < AW; k++)
        if (alloc_we[k]) begin
          live[alloc_idx[k]] <= 1'b1;
          done[alloc_idx[k]] <= 1'b0;
          misp[alloc_idx[k]] <= 1'b0;
        end
      for (int p = 0; p < CP; p++)
        if (cpl_hit[p]) begin
          done[cpl_tag[p]] <= 1'b1;
          misp[cpl_tag[p]] <= cpl_misp[p];
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < AW; k++)
      if (alloc_we[k]) dst_q[alloc_idx[k]] <= alloc_dst[k];
    for (int p = 0; p < CP; p++)
      if (cpl_hit[p]) val_q[cpl_tag[p]] <= cpl_value[p];
  end

  for (genvar k = 0; k < CW; k++) begin : g_rd
    assign rd_live[k]  = live[rd_idx[k]];
    assign rd_done[k]  = done[rd_idx[k]];
    assign rd_misp[k]  = misp[rd_idx[k]];
    assign rd_dst[k]   = dst_q[rd_idx[k]];
    assign rd_value[k] = val_q[rd_idx[k]];
  end

  for (genvar k = 0; k < AW; k++) begin : g_chk
    p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_we[k] |-> !live[alloc_idx[k]]);
  end
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned CW    = 3,
  parameter int unsigned TW    = 6,
  parameter int unsigned NCW   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TW-1:0]         head,
  input  logic                  cmt_ready,
  input  logic [CW-1:0]         rd_live,
  input  logic [CW-1:0]         rd_done,
  input  logic [CW-1:0]         rd_misp,
  output logic [CW-1:0][TW-1:0] rd_idx,
  output logic [CW-1:0]         ret,
  output logic [NCW-1:0]        ncmt,
  output logic                  squash,
  output logic [TW-1:0]         squash_tag
);
  import rob_pkg::*;

  for (genvar k = 0; k < CW; k++) begin : g_idx
    assign rd_idx[k] = TW'(ring_add(32'(head), 32'(k), DEPTH));
  end

  logic go;
  always_comb begin
    go         = cmt_ready;
    ret        = '0;
    ncmt       = '0;
    squash     = 1'b0;
    squash_tag = head;
    for (int k = 0; k < CW; k++) begin
      if (go && rd_live[k] && rd_done[k]) begin
        ret[k] = 1'b1;
        ncmt   = ncmt + NCW'(1);
        if (rd_misp[k]) begin
          squash     = 1'b1;
          squash_tag = rd_idx[k];
          go         = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
  end

  p_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret + CW'(1)) & ret) == '0);
  p_flush_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> $countones(ret & rd_misp) == 1);
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int unsigned DEPTH     = 40,
  parameter int unsigned ALLOC_W   = 3,
  parameter int unsigned CMT_W     = 3,
  parameter int unsigned CPL_PORTS = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_W     = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ALLOC_W-1:0]            alloc_valid,
  input  logic [ALLOC_W*REG_W-1:0]      alloc_dst,
  output logic                          alloc_ready,
  output logic [ALLOC_W*$clog2(DEPTH)-1:0] alloc_tag,
  input  logic [CPL_PORTS-1:0]          cpl_valid,
  input  logic [CPL_PORTS*$clog2(DEPTH)-1:0] cpl_tag,
  input  logic [CPL_PORTS*DATA_W-1:0]   cpl_value,
  input  logic [CPL_PORTS-1:0]          cpl_mispred,
  input  logic                          cmt_ready,
  output logic [CMT_W-1:0]              cmt_valid,
  output logic [CMT_W*REG_W-1:0]        cmt_dst,
  output logic [CMT_W*DATA_W-1:0]       cmt_value,
  output logic                          flush
);
  import rob_pkg::*;

  localparam int unsigned TW   = $clog2(DEPTH);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam int unsigned NAW  = $clog2(ALLOC_W + 1);
  localparam int unsigned NCW  = $clog2(CMT_W + 1);

  logic [TW-1:0]   head, tail, squash_tag;
  logic [CNTW-1:0] count, free_n;
  logic [NAW-1:0]  nreq, nacc;
  logic [NCW-1:0]  ncmt;
  logic            fire, squash;

  logic [ALLOC_W-1:0][TW-1:0]    a_idx;
  logic [ALLOC_W-1:0][REG_W-1:0] a_dst;
  logic [ALLOC_W-1:0]            a_we;
  logic [CPL_PORTS-1:0][TW-1:0]  c_tag;
  logic [CPL_PORTS-1:0][DATA_W-1:0] c_val;
  logic [CMT_W-1:0][TW-1:0]      r_idx;
  logic [CMT_W-1:0]              r_live, r_done, r_misp, ret;
  logic [CMT_W-1:0][REG_W-1:0]   r_dst;
  logic [CMT_W-1:0][DATA_W-1:0]  r_val;

  // Requested group size: the run of set lanes starting at lane 0.
  logic run;
  always_comb begin
    nreq = '0;
    run  = 1'b1;
    for (int k = 0; k < ALLOC_W; k++) begin
      if (run && alloc_valid[k]) nreq = nreq + NAW'(1);
      else                       run  = 1'b0;
    end
  end

  assign free_n      = CNTW'(DEPTH) - count;
  assign alloc_ready = !squash && (CNTW'(nreq) <= free_n);
  assign fire        = alloc_ready && (nreq != '0);
  assign nacc        = fire ? nreq : '0;

  for (genvar k = 0; k < ALLOC_W; k++) begin : g_alloc
    assign a_idx[k] = TW'(ring_add(32'(tail), 32'(k), DEPTH));
    assign a_dst[k] = alloc_dst[k*REG_W +: REG_W];
    assign a_we[k]  = fire && (NAW'(k) < nreq);
    assign alloc_tag[k*TW +: TW] = a_idx[k];
  end

  for (genvar p = 0; p < CPL_PORTS; p++) begin : g_cpl
    assign c_tag[p] = cpl_tag[p*TW +: TW];
    assign c_val[p] = cpl_value[p*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < CMT_W; k++) begin : g_cmt
    assign cmt_dst[k*REG_W +: REG_W]    = r_dst[k];
    assign cmt_value[k*DATA_W +: DATA_W] = r_val[k];
  end

  assign cmt_valid = ret;
  assign flush     = squash;

  rob_ptrs #(.DEPTH(DEPTH), .TW(TW), .CNTW(CNTW), .NAW(NAW), .NCW(NCW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .nacc(nacc), .ncmt(ncmt), .squash(squash),
    .squash_tag(squash_tag), .head(head), .tail(tail), .count(count)
  );

  rob_commit_sel #(.DEPTH(DEPTH), .CW(CMT_W), .TW(TW), .NCW(NCW)) u_sel (
    .clk(clk), .rst_n(rst_n), .head(head), .cmt_ready(cmt_ready),
    .rd_live(r_live), .rd_done(r_done), .rd_misp(r_misp), .rd_idx(r_idx),
    .ret(ret), .ncmt(ncmt), .squash(squash), .squash_tag(squash_tag)
  );

  rob_entries #(.DEPTH(DEPTH), .AW(ALLOC_W), .CW(CMT_W), .CP(CPL_PORTS),
                .DW(DATA_W), .RW(REG_W), .TW(TW)) u_ent (
    .clk(clk), .rst_n(rst_n), .alloc_we(a_we), .alloc_idx(a_idx), .alloc_dst(a_dst),
    .cpl_valid(cpl_valid), .cpl_tag(c_tag), .cpl_value(c_val), .cpl_misp(cpl_mispred),
    .ret_we(ret), .squash(squash), .rd_idx(r_idx), .rd_live(r_live),
    .rd_done(r_done), .rd_misp(r_misp), .rd_dst(r_dst), .rd_value(r_val)
  );

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((nreq != '0) && ((CNTW+1)'(count) + (CNTW+1)'(nreq) > (CNTW+1)'(DEPTH))) |-> !alloc_ready);
  p_flush_blocks_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !alloc_ready);
  p_hold_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_ready |-> (cmt_valid == '0));
endmodule

// File: tb/sim_reorder_buffer.sv
module sim_reorder_buffer;
  localparam int CLK_NS = 10;
  localparam int DEPTH = 40, AW = 3, CW = 3, CP = 2, DW = 32, RW = 5, TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic [AW-1:0]    a_valid = '0;
  logic [AW*RW-1:0] a_dst = '0;
  logic             a_ready;
  logic [AW*TW-1:0] a_tag;
  logic [CP-1:0]    c_valid = '0;
  logic [CP*TW-1:0] c_tag = '0;
  logic [CP*DW-1:0] c_val = '0;
  logic [CP-1:0]    c_misp = '0;
  logic             r_ready = 1'b0;
  logic [CW-1:0]    r_valid;
  logic [CW*RW-1:0] r_dst;
  logic [CW*DW-1:0] r_val;
  logic             flush;

  reorder_buffer #(.DEPTH(DEPTH), .ALLOC_W(AW), .CMT_W(CW), .CPL_PORTS(CP),
                   .DATA_W(DW), .REG_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a_valid), .alloc_dst(a_dst),
    .alloc_ready(a_ready), .alloc_tag(a_tag), .cpl_valid(c_valid), .cpl_tag(c_tag),
    .cpl_value(c_val), .cpl_mispred(c_misp), .cmt_ready(r_ready),
    .cmt_valid(r_valid), .cmt_dst(r_dst), .cmt_value(r_val), .flush(flush)
  );

  typedef struct {
    int          tag;
    int          dst;
    bit          done;
    logic [DW-1:0] val;
    bit          misp;
  } ent_t;

  ent_t q[$];
  int   next_tag = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    a_valid = '0; c_valid = '0; c_misp = '0; r_ready = 1'b0;
  endtask

  // Compare outputs with the model for the current cycle, then advance the model.
  task automatic step();
    int  nreq;
    bit  run;
    bit  sq;
    int  sqtag;
    int  nc;
    bit  ev [CW];
    bit  exp_ready;
    int  free_n;
    #1;
    nreq = 0; run = 1;
    for (int k = 0; k < AW; k++) begin
      if (run && a_valid[k]) nreq++;
      else run = 0;
    end
    sq = 0; sqtag = 0; nc = 0;
    for (int k = 0; k < CW; k++) ev[k] = 0;
    if (r_ready) begin
      for (int k = 0; k < CW; k++) begin
        if (k < q.size() && q[k].done) begin
          ev[k] = 1; nc++;
          if (q[k].misp) begin sq = 1; sqtag = q[k].tag; break; end
        end else break;
      end
    end
    free_n = DEPTH - q.size();
    exp_ready = !sq && (free_n >= nreq);
    if (sq)                   chk("R7", "alloc_ready during flush", a_ready, exp_ready);
    else if (free_n == 0)     chk("R9", "alloc_ready when full", a_ready, exp_ready);
    else                      chk("R2", "alloc_ready", a_ready, exp_ready);
    for (int k = 0; k < AW; k++)
      chk("R1", "alloc_tag lane", a_tag[k*TW +: TW], (next_tag + k) % DEPTH);
    chk("R6", "flush", flush, sq);
    for (int k = 0; k < CW; k++) begin
      if (!r_ready) chk("R5", "cmt_valid while held", r_valid[k], 0);
      else          chk("R4", "cmt_valid lane", r_valid[k], ev[k]);
      if (ev[k] && r_valid[k]) begin
        chk("R4", "cmt_dst lane", r_dst[k*RW +: RW], q[k].dst);
        chk("R3", "cmt_value lane", r_val[k*DW +: DW], q[k].val);
      end
    end
    // advance the model
    if (rst_n) begin
      for (int p = 0; p < CP; p++) begin
        if (c_valid[p]) begin
          for (int i = 0; i < q.size(); i++) begin
            if (q[i].tag == int'(c_tag[p*TW +: TW])) begin
              q[i].done = 1;
              q[i].val  = c_val[p*DW +: DW];
              q[i].misp = c_misp[p];
            end
          end
        end
      end
      for (int k = 0; k < nc; k++) void'(q.pop_front());
      if (sq) begin
        q.delete();
        next_tag = (sqtag + 1) % DEPTH;
      end else if (exp_ready && nreq > 0) begin
        for (int k = 0; k < nreq; k++) begin
          ent_t e;
          e.tag = next_tag; e.dst = int'(a_dst[k*RW +: RW]);
          e.done = 0; e.val = '0; e.misp = 0;
          q.push_back(e);
          next_tag = (next_tag + 1) % DEPTH;
        end
      end
    end
  endtask

  task automatic cycle();
    @(negedge clk);
  endtask

  // Report completion of the model entry at queue position pos on port p.
  task automatic complete(int p, int pos, bit m);
    c_valid[p] = 1'b1;
    c_tag[p*TW +: TW] = TW'(q[pos].tag);
    c_val[p*DW +: DW] = $urandom;
    c_misp[p] = m;
  endtask

  task automatic rand_cycle(int p_alloc, int p_cpl, int p_misp, int p_ready, int p_bad);
    a_valid = ($urandom_range(99) < p_alloc) ? AW'($urandom) : '0;
    a_dst   = (AW*RW)'($urandom);
    for (int p = 0; p < CP; p++) begin
      c_valid[p] = ($urandom_range(99) < p_cpl);
      c_misp[p]  = ($urandom_range(99) < p_misp);
      c_val[p*DW +: DW] = $urandom;
      if (q.size() == 0 || $urandom_range(99) < p_bad)
        c_tag[p*TW +: TW] = TW'($urandom_range(63));
      else
        c_tag[p*TW +: TW] = TW'(q[$urandom_range(q.size() - 1)].tag);
    end
    r_ready = ($urandom_range(99) < p_ready);
  endtask

  initial begin
    idle();
    cycle();
    // R8: reset state
    #1;
    chk("R8", "alloc_ready in reset", a_ready, 1);
    chk("R8", "tag lane 0 in reset", a_tag[TW-1:0], 0);
    chk("R8", "cmt_valid in reset", r_valid, 0);
    chk("R8", "flush in reset", flush, 0);
    cycle();
    rst_n = 1'b1;
    cycle(); idle(); step();

    // Fill to capacity with retirement held (R2, R9, R5)
    for (int i = 0; i < 15; i++) begin
      cycle(); idle(); a_valid = 3'b111; a_dst = (AW*RW)'($urandom); step();
    end
    cycle(); idle(); a_valid = 3'b001; step();
    cycle(); idle(); a_valid = 3'b101; step();

    // Out-of-order completion: younger done, oldest not (R4)
    cycle(); idle(); complete(0, 1, 0); complete(1, 2, 0); r_ready = 1; step();
    cycle(); idle(); r_ready = 1; step();
    cycle(); idle(); complete(0, 0, 0); r_ready = 1; step();
    cycle(); idle(); r_ready = 1; step();
    // Completion to unallocated tags is ignored (R3)
    cycle(); idle(); c_valid = 2'b11; c_tag = {TW'(50), TW'((next_tag + 1) % DEPTH)}; r_ready = 1; step();
    cycle(); idle(); r_ready = 1; step();

    // Mispredict in lane 1 with an allocation request in the same cycle (R6, R7)
    cycle(); idle(); complete(0, 0, 0); complete(1, 1, 1); step();
    cycle(); idle(); complete(0, 2, 0); step();
    cycle(); idle(); r_ready = 1; a_valid = 3'b011; step();
    cycle(); idle(); a_valid = 3'b111; step();

    // Random traffic under several mixes
    for (int i = 0; i < 1500; i++) begin
      cycle(); rand_cycle(70, 60, 3, 80, 10); step();
    end
    for (int i = 0; i < 800; i++) begin
      cycle(); rand_cycle(90, 30, 1, 50, 20); step();
    end
    for (int i = 0; i < 800; i++) begin
      cycle(); rand_cycle(40, 90, 10, 95, 5); step();
    end
    cycle(); idle(); step();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule